// File: doc/BRIEF.md
# Callee-Saved Register Frame Pusher

This block stores the callee-saved half of an exception stack frame to memory. A single-cycle start pulse launches it. At that edge it captures a stack pointer, eight general-purpose register values and an integrity signature word. It then issues a fixed series of single-word writes on a valid/acknowledge bus. When the series ends, it reports the lowered stack pointer and a one-cycle completion pulse. The block is built to sit beside an exception-entry sequencer. That sequencer has already pushed the caller-saved half and decides whether this half has to be stored at all.

The frame is ten words long and sits directly below the chosen stack pointer. The lowest word holds the signature. The word above it is left untouched. The eight register values fill the remaining eight words, in ascending order. In a normal entry the live stack pointer is used. When the entry is a tail-chain, one of two secure stack pointers is used instead. Two bits of the saved return link choose which one: the thread-mode bit and the stack-select bit.

The block reports which stack pointer was consumed, so the surrounding logic can write the new value back to the correct register.

Top module: `cs_frame_pusher`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge show `wr_valid_o` = 0 and `done_o` = 0, and the block is idle.
- R2: When a start is accepted, the frame base equals the selected stack pointer minus 0x28. `new_sp_o` shows this base while `done_o` is high.
- R3: The first write of each sequence goes to frame base + 0x00 and carries the `sig_i` value captured at start. The bench uses the value 0xFEFA125B.
- R4: Writes two to nine carry r4..r11 to base + 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24, in that order. `regs_i[31:0]` holds r4 and `regs_i[255:224]` holds r11. Base + 0x04 is never written, and every write address is word aligned.
- R5: While `wr_valid_o` is high and `wr_ack_i` is low, the next cycle keeps `wr_valid_o` high with the same address and data.
- R6: Each accepted start produces exactly nine acknowledged writes. `done_o` goes high for exactly one cycle, in the cycle after the ninth acknowledge, and no write is valid in that cycle.
- R7: When `tail_i` = 0, the live pointer `cur_sp_i` is used and `sp_dest_o` reads 0 while `done_o` is high.
- R8: When `tail_i` = 1 and both `ret_thread_i` and `ret_psp_i` are 1, `sec_psp_i` is used and `sp_dest_o` reads 2. In every other tail-chain case `sec_msp_i` is used and `sp_dest_o` reads 1.
- R9: A start pulse that arrives while a sequence is in progress has no effect on the writes, on their count or on `new_sp_o`.
- R10: A synchronous reset during a sequence abandons it. `wr_valid_o` is low after that edge, and a later start runs a complete, correct sequence.
- R11: Stack pointers, registers and the signature are captured at the accepted start. Later changes to them do not alter the sequence in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| tail_i | input | 1 | Tail-chain entry: use a secure stack pointer |
| ret_thread_i | input | 1 | Return-link bit: return to thread mode |
| ret_psp_i | input | 1 | Return-link bit: process stack selected |
| cur_sp_i | input | AW | Live stack pointer |
| sec_msp_i | input | AW | Secure main stack pointer |
| sec_psp_i | input | AW | Secure process stack pointer |
| regs_i | input | NREGS*DW | r4..r11 packed, r4 in the lowest word |
| sig_i | input | DW | Integrity signature word |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | DW | Write data |
| wr_ack_i | input | 1 | Write accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| new_sp_o | output | AW | Lowered stack pointer (frame base) |
| sp_dest_o | output | 2 | Pointer consumed: 0 live, 1 secure main, 2 secure process |

## Verification
The bound checker covers the cycle-level rules on every clock:
- requests hold while unacknowledged;
- addresses stay word aligned;
- `done_o` lasts one cycle and follows an acknowledge;
- exactly nine acknowledges fall between completions;
- the reported stack pointer sits 0x24 below the last write address;
- reset clears the outputs.

Other behaviour can only be shown by the bench's reference model with directed scenarios. This covers the exact address and data of every slot, the skipped reserved word, and the pointer selection in each tail-chain case. It also covers ignoring a start while busy, capture of the inputs at start, and recovery after a reset in the middle of a sequence.

// File: rtl/cse_pkg.sv
package cse_pkg;

  // which stack pointer a sequence consumed
  typedef enum logic [1:0] {
    SPD_LIVE     = 2'd0,
    SPD_SEC_MAIN = 2'd1,
    SPD_SEC_PROC = 2'd2
  } sp_dest_e;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_PUSH = 1'b1
  } push_state_e;

endpackage

// File: rtl/cse_sp_select.sv
module cse_sp_select
  import cse_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          tail_i,
  input  logic          ret_thread_i,
  input  logic          ret_psp_i,
  input  logic [AW-1:0] cur_sp_i,
  input  logic [AW-1:0] sec_msp_i,
  input  logic [AW-1:0] sec_psp_i,
  output logic [AW-1:0] sp_o,
  output sp_dest_e      dest_o
);

  always_comb begin
    if (!tail_i) begin
      sp_o   = cur_sp_i;
      dest_o = SPD_LIVE;
    end else if (ret_thread_i && ret_psp_i) begin
      sp_o   = sec_psp_i;
      dest_o = SPD_SEC_PROC;
    end else begin
      sp_o   = sec_msp_i;
      dest_o = SPD_SEC_MAIN;
    end
  end

endmodule

// File: rtl/cse_slot_map.sv
module cse_slot_map #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int IW    = $clog2(NREGS + 1)
) (
  input  logic [AW-1:0]       base_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [DW-1:0]       sig_i,
  input  logic [NREGS*DW-1:0] regs_i,
  output logic [AW-1:0]       addr_o,
  output logic [DW-1:0]       data_o
);

  localparam int WB    = DW / 8;
  localparam int NSLOT = NREGS + 1;

  // slot 0 is the signature; slot k holds register k-1 one word higher
  logic [DW-1:0] slot_data [NSLOT];
  logic [AW-1:0] offset;

  assign slot_data[0] = sig_i;
  for (genvar k = 1; k < NSLOT; k++) begin : g_slot
    assign slot_data[k] = regs_i[(k-1)*DW +: DW];
  end

  always_comb begin
    if (idx_i == '0) offset = '0;
    else             offset = AW'((int'(idx_i) + 1) * WB);
    addr_o = base_i + offset;
    data_o = (int'(idx_i) < NSLOT) ? slot_data[idx_i] : '0;
  end

endmodule

// File: rtl/cs_frame_pusher.sv
module cs_frame_pusher
  import cse_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NREGS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                tail_i,
  input  logic                ret_thread_i,
  input  logic                ret_psp_i,
  input  logic [AW-1:0]       cur_sp_i,
  input  logic [AW-1:0]       sec_msp_i,
  input  logic [AW-1:0]       sec_psp_i,
  input  logic [NREGS*DW-1:0] regs_i,
  input  logic [DW-1:0]       sig_i,
  output logic                wr_valid_o,
  output logic [AW-1:0]       wr_addr_o,
  output logic [DW-1:0]       wr_data_o,
  input  logic                wr_ack_i,
  output logic                done_o,
  output logic [AW-1:0]       new_sp_o,
  output logic [1:0]          sp_dest_o
);

  localparam int WB          = DW / 8;
  localparam int NSLOT       = NREGS + 1;
  localparam int IW          = $clog2(NSLOT);
  localparam int FRAME_BYTES = (NREGS + 2) * WB;

  push_state_e         state_q;
  logic [IW-1:0]       idx_q, nidx;
  logic [AW-1:0]       base_q, sel_sp, map_base, slot_addr;
  logic [DW-1:0]       sig_q, map_sig, slot_data;
  logic [NREGS*DW-1:0] regs_q, map_regs;
  sp_dest_e            sel_dest, dest_q;
  logic                accept, last;

  cse_sp_select #(.AW(AW)) u_sel (
    .tail_i       (tail_i),
    .ret_thread_i (ret_thread_i),
    .ret_psp_i    (ret_psp_i),
    .cur_sp_i     (cur_sp_i),
    .sec_msp_i    (sec_msp_i),
    .sec_psp_i    (sec_psp_i),
    .sp_o         (sel_sp),
    .dest_o       (sel_dest)
  );

  cse_slot_map #(.AW(AW), .DW(DW), .NREGS(NREGS), .IW(IW)) u_map (
    .base_i (map_base),
    .idx_i  (nidx),
    .sig_i  (map_sig),
    .regs_i (map_regs),
    .addr_o (slot_addr),
    .data_o (slot_data)
  );

  // on acceptance the map sees live inputs, later it sees the captured copy
  always_comb begin
    accept   = (state_q == PS_IDLE) && start_i;
    last     = (idx_q == IW'(NSLOT - 1));
    nidx     = accept ? '0 : idx_q + 1'b1;
    map_base = accept ? sel_sp - AW'(FRAME_BYTES) : base_q;
    map_sig  = accept ? sig_i  : sig_q;
    map_regs = accept ? regs_i : regs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PS_IDLE;
      idx_q      <= '0;
      base_q     <= '0;
      sig_q      <= '0;
      regs_q     <= '0;
      dest_q     <= SPD_LIVE;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      done_o     <= 1'b0;
      new_sp_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        PS_IDLE: begin
          if (accept) begin
            state_q    <= PS_PUSH;
            idx_q      <= '0;
            base_q     <= map_base;
            sig_q      <= sig_i;
            regs_q     <= regs_i;
            dest_q     <= sel_dest;
            wr_valid_o <= 1'b1;
            wr_addr_o  <= slot_addr;
            wr_data_o  <= slot_data;
          end
        end
        PS_PUSH: begin
          if (wr_ack_i) begin
            if (last) begin
              state_q    <= PS_IDLE;
              wr_valid_o <= 1'b0;
              done_o     <= 1'b1;
              new_sp_o   <= base_q;
            end else begin
              idx_q     <= nidx;
              wr_addr_o <= slot_addr;
              wr_data_o <= slot_data;
            end
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign sp_dest_o = dest_q;

endmodule

// File: rtl/cs_frame_pusher_chk.sv
module cs_frame_pusher_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NREGS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                tail_i,
  input logic                ret_thread_i,
  input logic                ret_psp_i,
  input logic [AW-1:0]       cur_sp_i,
  input logic [AW-1:0]       sec_msp_i,
  input logic [AW-1:0]       sec_psp_i,
  input logic [NREGS*DW-1:0] regs_i,
  input logic [DW-1:0]       sig_i,
  input logic                wr_valid_o,
  input logic [AW-1:0]       wr_addr_o,
  input logic [DW-1:0]       wr_data_o,
  input logic                wr_ack_i,
  input logic                done_o,
  input logic [AW-1:0]       new_sp_o,
  input logic [1:0]          sp_dest_o
);

  localparam int WB       = DW / 8;
  localparam int LAST_OFF = (NREGS + 1) * WB;

  logic [7:0] ack_cnt;

  always_ff @(posedge clk) begin
    if (rst || done_o)                ack_cnt <= '0;
    else if (wr_valid_o && wr_ack_i)  ack_cnt <= ack_cnt + 1'b1;
  end

  // R5: an unacknowledged request is held unchanged
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o && !wr_ack_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R4: every address is word aligned
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (wr_addr_o & AW'(WB - 1)) == '0);

  // R6: completion is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: completion follows an acknowledge and no write overlaps it
  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(wr_valid_o && wr_ack_i) && !wr_valid_o);

  // R6: nine acknowledged writes per sequence
  a_r6_nine_writes: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ack_cnt == 8'(NREGS + 1));

  // R2: the reported pointer lies just below the last slot written
  a_r2_sp_below_last: assert property (@(posedge clk) disable iff (rst)
    done_o |-> new_sp_o == $past(wr_addr_o) - AW'(LAST_OFF));

  // R1 / R10: reset clears the request and the completion pulse
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> !wr_valid_o && !done_o);

endmodule

bind cs_frame_pusher cs_frame_pusher_chk #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_chk (.*);

// File: tb/sim_cs_frame_pusher.sv
`timescale 1ns/1ps
module sim_cs_frame_pusher;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0, tail_i = 1'b0, ret_thread_i = 1'b0, ret_psp_i = 1'b0;
  logic [31:0]  cur_sp_i = '0, sec_msp_i = '0, sec_psp_i = '0;
  logic [255:0] regs_i = '0;
  logic [31:0]  sig_i = 32'hFEFA125B;
  logic         wr_valid_o, wr_ack_i = 1'b0, done_o;
  logic [31:0]  wr_addr_o, wr_data_o, new_sp_o;
  logic [1:0]   sp_dest_o;

  always #5 clk = ~clk;

  cs_frame_pusher u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, ack_mode = 0, nwr = 0;
  bit cmp_en = 0;

  // reference model state
  bit          m_busy = 0, m_done = 0;
  int          m_idx = 0, m_dest = 0;
  logic [31:0] m_base = '0, m_sig = '0, m_nsp = '0;
  logic [31:0] m_regs [8];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // model advances on the edge, using only bench-driven inputs
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (wr_ack_i) begin
          if (m_idx == 8) begin m_busy = 0; m_done = 1; m_nsp = m_base; end
          else m_idx++;
        end
      end else if (start_i) begin
        logic [31:0] sp;
        if (!tail_i)                      begin sp = cur_sp_i;  m_dest = 0; end
        else if (ret_thread_i && ret_psp_i) begin sp = sec_psp_i; m_dest = 2; end
        else                              begin sp = sec_msp_i; m_dest = 1; end
        m_base = sp - 32'h28;
        m_sig  = sig_i;
        for (int k = 0; k < 8; k++) m_regs[k] = regs_i[k*32 +: 32];
        m_idx = 0; m_busy = 1;
      end
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // acknowledge pattern, driven shortly after the edge
  always @(posedge clk) begin
    #2;
    case (ack_mode)
      0:       wr_ack_i <= 1'b1;
      1:       wr_ack_i <= (cyc % 3 == 0);
      default: wr_ack_i <= 1'b0;
    endcase
  end

  // compare every cycle, mid-period
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      logic [31:0] ea, ed;
      chk(wr_valid_o === m_busy, "R6 valid", 32'(wr_valid_o), 32'(m_busy));
      if (m_busy) begin
        ea = m_base + ((m_idx == 0) ? 32'h0 : 32'((m_idx + 1) * 4));
        ed = (m_idx == 0) ? m_sig : m_regs[m_idx-1];
        chk(wr_addr_o === ea, (m_idx == 0) ? "R3 addr" : "R4 addr", wr_addr_o, ea);
        chk(wr_data_o === ed, (m_idx == 0) ? "R3 data" : "R4/R11 data", wr_data_o, ed);
        if (wr_ack_i) nwr++;
      end
      if (wr_valid_o && wr_addr_o === m_base + 32'h4)
        chk(0, "R4 reserved slot written", wr_addr_o, m_base);
      chk(done_o === m_done, "R6 done", 32'(done_o), 32'(m_done));
      if (m_done) begin
        chk(new_sp_o === m_nsp, "R2 new_sp", new_sp_o, m_nsp);
        chk(32'(sp_dest_o) === 32'(m_dest), "R7/R8 dest", 32'(sp_dest_o), 32'(m_dest));
      end
    end
  end

  task automatic launch(bit tl, bit md, bit sl, logic [31:0] cur, logic [31:0] msp,
                        logic [31:0] psp);
    @(negedge clk);
    tail_i = tl; ret_thread_i = md; ret_psp_i = sl;
    cur_sp_i = cur; sec_msp_i = msp; sec_psp_i = psp;
    for (int k = 0; k < 8; k++) regs_i[k*32 +: 32] = $urandom;
    nwr = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 300 && !done_o; t++) @(negedge clk);
  endtask

  task automatic finish_one(string req, logic [31:0] exp_sp, int exp_dest);
    wait_done();
    chk(done_o === 1'b1, {req, " done seen"}, 32'(done_o), 32'h1);
    chk(new_sp_o === exp_sp - 32'h28, {req, " R2 base"}, new_sp_o, exp_sp - 32'h28);
    chk(32'(sp_dest_o) === 32'(exp_dest), req, 32'(sp_dest_o), 32'(exp_dest));
    chk(nwr == 9, "R6 write count", 32'(nwr), 32'd9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp_en = 1;
    rst = 1'b0;
    // R1: idle after reset
    chk(wr_valid_o === 1'b0, "R1 valid", 32'(wr_valid_o), 32'h0);
    chk(done_o === 1'b0, "R1 done", 32'(done_o), 32'h0);

    // R7: live pointer, fast acknowledge
    ack_mode = 0;
    launch(0, 1, 1, 32'h2000_1000, 32'h3000_0000, 32'h3100_0000);
    finish_one("R7 live", 32'h2000_1000, 0);

    // R8: tail-chain with process stack, slow acknowledge
    ack_mode = 1;
    launch(1, 1, 1, 32'h2000_1000, 32'h3000_0400, 32'h3100_0800);
    finish_one("R8 psp", 32'h3100_0800, 2);
    launch(1, 1, 0, 32'h2000_1000, 32'h3000_0400, 32'h3100_0800);
    finish_one("R8 msp sel0", 32'h3000_0400, 1);
    launch(1, 0, 1, 32'h2000_1000, 32'h3000_0600, 32'h3100_0800);
    finish_one("R8 msp handler", 32'h3000_0600, 1);

    // R5: stall then resume
    ack_mode = 2;
    launch(0, 0, 0, 32'h2000_2000, 32'h0, 32'h0);
    repeat (5) @(negedge clk);
    chk(wr_valid_o === 1'b1 && wr_addr_o === 32'h2000_1FD8, "R5 stalled hold",
        wr_addr_o, 32'h2000_1FD8);
    ack_mode = 0;
    finish_one("R5 resume", 32'h2000_2000, 0);

    // R9 + R11: extra start and input changes while busy
    ack_mode = 1;
    launch(0, 0, 0, 32'h2000_4000, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    cur_sp_i = 32'h2000_9000;
    regs_i = {8{32'hDEAD_BEEF}};
    sig_i = 32'h1234_5678;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_one("R9 ignored start", 32'h2000_4000, 0);
    sig_i = 32'hFEFA125B;

    // R10: reset mid-sequence, then a clean run
    launch(0, 0, 0, 32'h2000_6000, 32'h0, 32'h0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(wr_valid_o === 1'b0, "R10 abort valid", 32'(wr_valid_o), 32'h0);
    rst = 1'b0;
    ack_mode = 0;
    launch(0, 0, 0, 32'h2000_7000, 32'h0, 32'h0);
    finish_one("R10 rerun", 32'h2000_7000, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule